// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block steps an LCD display chain through a fixed bring-up and shut-down order. The chain is panel supply, video serializer, video deserializer, video source and backlight. On the way up it powers the panel with the backlight dark. After a ramp interval and a further settle interval it starts the video source on black content. It then takes the serializer and the deserializer out of shutdown, one after the other. Black content is held long enough for the link to lock, then the real image is selected, and only after that does the backlight turn on.

On the way down the backlight goes dark first. After a minimum dark time the video switches to black, and it stays black for a programmed number of frame-start pulses. Only then does the block put the serializer into shutdown and then the deserializer, each followed by a guard interval. The video source is stopped next, and panel supply is removed last. All intervals are counts of clock cycles set by parameters, and each must be at least 1.

Requests that arrive in the middle of a sequence are held. A stop request made during bring-up is served as soon as the fully-on state is reached. A start request made during shut-down is served as soon as the fully-off state is reached.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While reset is high, and on the cycle after any reset edge, the outputs take their off values. All enables are low, both shutdown outputs are low (asserted), the black select is high, and busy and ready are low.
- R2: A start request sampled in the off state raises panel power on the next cycle. The video source enable rises RAMP_CYC + SETTLE_CYC cycles later, with the black select high.
- R3: The serializer shutdown output goes high GAP_CYC cycles after the video source enable rises. The deserializer shutdown output goes high GAP_CYC cycles after that. The deserializer is never released before the serializer.
- R4: The black select falls HOLD_CYC cycles after the deserializer is released. The backlight enable rises GAP_CYC cycles after the black select falls.
- R5: A stop request sampled in the fully-on state drops the backlight on the next cycle. The black select rises BLOFF_CYC cycles later.
- R6: Once the black select has risen during shut-down, the serializer shutdown output falls on the cycle after the FRAMES-th frame-start pulse is sampled. Frame-start pulses seen earlier, during the backlight-off wait, are not counted.
- R7: The deserializer shutdown output falls SDGAP_CYC cycles after the serializer's. The video source enable falls SDGAP_CYC cycles after that. Panel power falls GAP_CYC cycles later.
- R8: A stop request during bring-up is held, and the fully-on state then lasts exactly one cycle before the backlight drops.
- R9: A start request during shut-down is held, and the off state then lasts exactly one cycle before panel power rises again.
- R10: Ready is high only in the fully-on state, and busy is high only in intermediate states. A start request in the fully-on state has no effect.
- R11: The backlight is on only while panel power, the video source and both link stages are enabled and the image (not black) is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_req | input | 1 | Start request (sampled each cycle) |
| pwr_off_req | input | 1 | Stop request (sampled each cycle) |
| frame_start | input | 1 | One-cycle pulse at each video frame start |
| panel_pwr_en | output | 1 | Panel supply enable |
| black_sel | output | 1 | 1 = black content, 0 = image |
| src_en | output | 1 | Video source enable |
| ser_sd_n | output | 1 | Serializer shutdown, active low |
| des_sd_n | output | 1 | Deserializer shutdown, active low |
| bl_en | output | 1 | Backlight enable |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Fully on |

## Verification
The bench runs a plain bring-up followed by a plain shut-down. This fixes the exact cycle of every output edge against the interval parameters. In the shut-down it sends a frame-start pulse too early, and then spaces three pulses unevenly, which shows whether frames are counted only in the black phase. A stop request placed during the serializer stage, and a start request placed during the serializer shutdown, show whether held requests produce the one-cycle on and off visits. A start request while fully on, and a reset while fully on, cover the cases where requests are ignored and the block is forced off.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [3:0] {
        S_OFF, S_RAMP, S_SETTLE, S_SRC, S_SER, S_HOLD, S_IMG, S_ON,
        S_BLOFF, S_BLACK, S_SERDN, S_DESDN, S_SRCDN
    } seq_state_e;

    typedef struct packed {
        logic pwr;
        logic src;
        logic black;
        logic ser_n;
        logic des_n;
        logic bl;
        logic busy;
        logic ready;
    } seq_out_t;

    function automatic seq_state_e succ(input seq_state_e s);
        case (s)
            S_OFF:    return S_RAMP;
            S_RAMP:   return S_SETTLE;
            S_SETTLE: return S_SRC;
            S_SRC:    return S_SER;
            S_SER:    return S_HOLD;
            S_HOLD:   return S_IMG;
            S_IMG:    return S_ON;
            S_ON:     return S_BLOFF;
            S_BLOFF:  return S_BLACK;
            S_BLACK:  return S_SERDN;
            S_SERDN:  return S_DESDN;
            S_DESDN:  return S_SRCDN;
            default:  return S_OFF;
        endcase
    endfunction

    function automatic seq_out_t decode(input seq_state_e s);
        seq_out_t o;
        o = '{pwr: 1'b1, src: 1'b1, black: 1'b1, ser_n: 1'b1,
              des_n: 1'b1, bl: 1'b0, busy: 1'b1, ready: 1'b0};
        case (s)
            S_OFF:    begin o.pwr = 0; o.src = 0; o.ser_n = 0; o.des_n = 0; o.busy = 0; end
            S_RAMP,
            S_SETTLE,
            S_SRCDN:  begin o.src = 0; o.ser_n = 0; o.des_n = 0; end
            S_SRC,
            S_DESDN:  begin o.ser_n = 0; o.des_n = 0; end
            S_SER:    o.des_n = 0;
            S_SERDN:  o.ser_n = 0;
            S_IMG,
            S_BLOFF:  o.black = 0;
            S_ON:     begin o.black = 0; o.bl = 1; o.busy = 0; o.ready = 1; end
            default:  ;
        endcase
        return o;
    endfunction

    function automatic int bits_for(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    p_tmr_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));
    p_tmr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/lcd_seq_frames.sv
module lcd_seq_frames #(
    parameter int FRAMES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic active,
    input  logic frame_start,
    output logic done
);
    localparam int FW = lcd_seq_pkg::bits_for(FRAMES);
    logic [FW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)                 cnt <= '0;
        else if (active && frame_start) cnt <= cnt + 1'b1;
    end

    assign done = active && frame_start && (cnt == FW'(FRAMES - 1));

    p_frm_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt < FW'(FRAMES));
    p_frm_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!active && !clr) |=> $stable(cnt));
endmodule

// File: rtl/lcd_seq_reqs.sv
module lcd_seq_reqs (
    input  logic clk,
    input  logic rst,
    input  logic at_off,
    input  logic at_on,
    input  logic on_req,
    input  logic off_req,
    output logic go_up,
    output logic go_dn
);
    logic pend_on, pend_off;

    always_ff @(posedge clk) begin
        if (rst || at_off || at_on) begin
            pend_on  <= 1'b0;
            pend_off <= 1'b0;
        end else begin
            if (on_req)  pend_on  <= 1'b1;
            if (off_req) pend_off <= 1'b1;
        end
    end

    assign go_up = at_off && (on_req || pend_on);
    assign go_dn = at_on && (off_req || pend_off);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (on_req && !at_off && !at_on) |=> pend_on);
    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (off_req && !at_off && !at_on) |=> pend_off);
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcd_seq_pkg::*;
#(
    parameter int RAMP_CYC   = 100000,
    parameter int SETTLE_CYC = 2000000,
    parameter int GAP_CYC    = 100,
    parameter int HOLD_CYC   = 120000,
    parameter int BLOFF_CYC  = 50000,
    parameter int SDGAP_CYC  = 30,
    parameter int FRAMES     = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_on_req,
    input  logic pwr_off_req,
    input  logic frame_start,
    output logic panel_pwr_en,
    output logic black_sel,
    output logic src_en,
    output logic ser_sd_n,
    output logic des_sd_n,
    output logic bl_en,
    output logic busy,
    output logic ready
);
    localparam int MAXC = imax(imax(imax(RAMP_CYC, SETTLE_CYC), imax(GAP_CYC, HOLD_CYC)),
                               imax(BLOFF_CYC, SDGAP_CYC));
    localparam int W = bits_for(MAXC);

    seq_state_e cur, nxt;
    seq_out_t   o;
    logic       t_done, f_done, go_up, go_dn, advance, load;
    logic [W-1:0] load_val;

    lcd_seq_reqs u_reqs (
        .clk(clk), .rst(rst),
        .at_off(cur == S_OFF), .at_on(cur == S_ON),
        .on_req(pwr_on_req), .off_req(pwr_off_req),
        .go_up(go_up), .go_dn(go_dn)
    );

    lcd_seq_timer #(.W(W)) u_tmr (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .done(t_done)
    );

    lcd_seq_frames #(.FRAMES(FRAMES)) u_frm (
        .clk(clk), .rst(rst), .clr(load), .active(cur == S_BLACK),
        .frame_start(frame_start), .done(f_done)
    );

    always_comb begin
        case (cur)
            S_OFF:   advance = go_up;
            S_ON:    advance = go_dn;
            S_BLACK: advance = f_done;
            default: advance = t_done;
        endcase
        nxt  = advance ? succ(cur) : cur;
        load = (nxt != cur);
        case (nxt)
            S_RAMP:   load_val = W'(RAMP_CYC - 1);
            S_SETTLE: load_val = W'(SETTLE_CYC - 1);
            S_HOLD:   load_val = W'(HOLD_CYC - 1);
            S_BLOFF:  load_val = W'(BLOFF_CYC - 1);
            S_SERDN,
            S_DESDN:  load_val = W'(SDGAP_CYC - 1);
            S_SRC, S_SER, S_IMG, S_SRCDN:
                      load_val = W'(GAP_CYC - 1);
            default:  load_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= S_OFF;
        else     cur <= nxt;
    end

    assign o            = decode(cur);
    assign panel_pwr_en = o.pwr;
    assign src_en       = o.src;
    assign black_sel    = o.black;
    assign ser_sd_n     = o.ser_n;
    assign des_sd_n     = o.des_n;
    assign bl_en        = o.bl;
    assign busy         = o.busy;
    assign ready        = o.ready;

    p_rst_off_r1: assert property (@(posedge clk)
        rst |=> (!panel_pwr_en && !src_en && !ser_sd_n && !des_sd_n && !bl_en
                 && black_sel && !busy && !ready));
    p_src_needs_pwr_r2: assert property (@(posedge clk) disable iff (rst)
        src_en |-> panel_pwr_en);
    p_des_after_ser_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(des_sd_n) |-> $past(ser_sd_n));
    p_bl_gate_r11: assert property (@(posedge clk) disable iff (rst)
        bl_en |-> (panel_pwr_en && src_en && ser_sd_n && des_sd_n && !black_sel));
    p_bl_first_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(bl_en) |-> (ser_sd_n && des_sd_n && !black_sel));
    p_ser_first_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(des_sd_n) |-> $past(!ser_sd_n));
    p_pwr_last_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(panel_pwr_en) |-> (!src_en && !ser_sd_n && !des_sd_n));
    p_ready_excl_r10: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!busy && bl_en));
endmodule

// File: tb/sim_lcd_pwr_seq.sv
module sim_lcd_pwr_seq;
    localparam int RAMP = 5, SETTLE = 4, GAP = 3, HOLD = 6, BLOFF = 4, SDGAP = 2, FR = 3;

    localparam logic [7:0] V_OFF  = 8'b0010_0000;
    localparam logic [7:0] V_PWR  = 8'b1010_0010;
    localparam logic [7:0] V_SRC  = 8'b1110_0010;
    localparam logic [7:0] V_SER  = 8'b1111_0010;
    localparam logic [7:0] V_BLK  = 8'b1111_1010;
    localparam logic [7:0] V_IMG  = 8'b1101_1010;
    localparam logic [7:0] V_ON   = 8'b1101_1101;
    localparam logic [7:0] V_SDN  = 8'b1110_1010;

    typedef struct { int t; logic [7:0] v; string tag; } item_t;

    logic clk = 0, rst = 1, on_req = 0, off_req = 0, fs = 0;
    logic pwr, blk, src, ser_n, des_n, bl, busy, ready;
    int cyc = 0, checks = 0, errors = 0;
    bit mon_en = 0;
    item_t q[$];
    logic [7:0] exp_v = V_OFF;
    string exp_tag = "R1";

    always #4 clk = ~clk;

    lcd_pwr_seq #(.RAMP_CYC(RAMP), .SETTLE_CYC(SETTLE), .GAP_CYC(GAP), .HOLD_CYC(HOLD),
                  .BLOFF_CYC(BLOFF), .SDGAP_CYC(SDGAP), .FRAMES(FR)) u0 (
        .clk(clk), .rst(rst), .pwr_on_req(on_req), .pwr_off_req(off_req),
        .frame_start(fs), .panel_pwr_en(pwr), .black_sel(blk), .src_en(src),
        .ser_sd_n(ser_n), .des_sd_n(des_n), .bl_en(bl), .busy(busy), .ready(ready)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 3000) begin
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected end before 3000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // monitor: pop expected items due by this cycle, compare the whole output vector
    always @(negedge clk) begin
        if (mon_en) begin
            while (q.size() > 0 && q[0].t <= cyc) begin
                exp_v   = q[0].v;
                exp_tag = q[0].tag;
                void'(q.pop_front());
            end
            checks++;
            if ({pwr, src, blk, ser_n, des_n, bl, busy, ready} !== exp_v) begin
                errors++;
                $display("FAIL %s cycle %0d: actual %b expected %b", exp_tag, cyc,
                         {pwr, src, blk, ser_n, des_n, bl, busy, ready}, exp_v);
            end
        end
    end

    task automatic push(input int t, input logic [7:0] v, input string tag);
        item_t it;
        it.t = t; it.v = v; it.tag = tag;
        q.push_back(it);
    endtask

    // bring-up expected after a start accepted at cycle c (R2, R3, R4, R10, R11)
    task automatic up_push(input int c, input string tag0, output int t_on);
        int t;
        t = c + 1;      push(t, V_PWR, tag0);
        t += RAMP;      push(t, V_PWR, "R2");
        t += SETTLE;    push(t, V_SRC, "R2");
        t += GAP;       push(t, V_SER, "R3");
        t += GAP;       push(t, V_BLK, "R3");
        t += HOLD;      push(t, V_IMG, "R4");
        t += GAP;       push(t, V_ON,  "R4/R10/R11");
        t_on = t;
    endtask

    // shut-down tail after black starts at tb, with pulses at tb+1, tb+3, tb+6 (R6, R7)
    task automatic down_push(input int tb, output int t_off);
        int t;
        t = tb + 7;     push(t, V_SDN, "R6");
        t += SDGAP;     push(t, V_SRC, "R7");
        t += SDGAP;     push(t, V_PWR, "R7");
        t += GAP;       push(t, V_OFF, "R7");
        t_off = t;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse(input int c, input int which);
        wait_to(c);
        if (which == 0) on_req = 1; else if (which == 1) off_req = 1; else fs = 1;
        @(negedge clk);
        on_req = 0; off_req = 0; fs = 0;
    endtask

    task automatic frames(input int tb);
        pulse(tb + 1, 2);
        pulse(tb + 3, 2);
        pulse(tb + 6, 2);
    endtask

    initial begin
        int t_on, t_off;
        @(negedge clk);
        wait_to(2);
        mon_en = 1;                          // R1: outputs during reset
        wait_to(4);
        rst = 0;

        // plain bring-up then an ignored start request while on
        up_push(10, "R2", t_on);
        push(t_on + 6, V_ON, "R10");
        pulse(10, 0);
        pulse(t_on + 5, 0);

        // plain shut-down with an early, uncounted frame pulse
        push(51, V_IMG, "R5");
        push(55, V_BLK, "R5");
        down_push(55, t_off);
        pulse(50, 1);
        pulse(52, 2);                        // R6: during backlight-off wait
        frames(55);
        wait_to(t_off + 3);

        // stop request held during bring-up
        up_push(80, "R2", t_on);
        push(t_on + 1, V_IMG, "R8");
        push(t_on + 1 + BLOFF, V_BLK, "R5");
        down_push(t_on + 1 + BLOFF, t_off);
        pulse(80, 0);
        pulse(94, 1);                        // serializer stage
        frames(t_on + 1 + BLOFF);
        wait_to(t_off + 3);

        // start request held during shut-down
        up_push(140, "R2", t_on);
        push(t_on + 6, V_IMG, "R5");
        push(t_on + 10, V_BLK, "R5");
        down_push(t_on + 10, t_off);
        up_push(t_off, "R9", t_on);
        pulse(140, 0);
        pulse(170, 1);
        frames(175);
        pulse(183, 0);                       // during serializer shutdown
        wait_to(t_on + 4);

        // reset while fully on
        push(t_on + 6, V_OFF, "R1");
        wait_to(t_on + 5);
        rst = 1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;
        wait_to(t_on + 14);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule